// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer with Register Window

The block is a watchdog counter for a chip's power-management domain. Software reaches it over a simple register bus that has two spaces. The setup space holds a configuration register and a window register. The configuration register enables the watchdog and picks its tick source. The window register turns address decoding on and sets the base address of the two run-time registers. The run-time space holds those two registers: a control register and a reload register.

The counter is fed by two single-cycle tick inputs, a fast one (about 32 kHz) and a slow one (1 Hz). Writing one to the trigger bit of the control register loads the counter from the reload value and arms it. While the watchdog is enabled and running, each tick from the selected source counts the value down. When the countdown runs out, the block raises a one-cycle pulse on either its system-reset output or its power-off output, as the control register selects. Software bring-up follows this order: enable and pick the rate, place the window, load the reload value, set run, then trigger.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the configuration register (setup space, offset 0) reads 0x1 (disabled, fast tick). The window register (setup space, offset 4) reads 0. Both pulse outputs are low.
- R2: In the configuration register, bit 0 disables the watchdog when 1, and bits 2:1 hold the rate code. In the window register, bit 0 enables decoding and bits 31:3 hold the base. Bits 2:1 of the window register and bits 31:3 of the configuration register read as 0.
- R3: The control register sits at base+0 and the reload register at base+4 in the run-time space. It answers only when decoding is enabled and address bits 31:3 equal the base. Otherwise writes are ignored and reads return 0.
- R4: In the control register, bit 0 is run, bit 2 is the action (0 = reset, 1 = power-off) and bit 3 is a local disable. A write with bit 7 set loads the counter from bits 15:0 of the reload register and arms it. Bit 7 always reads 0. The reload register reads back only its low 16 bits.
- R5: The counter holds its value while any of these is true: the configuration disable is 1, the control disable is 1, or run is 0. Once all three conditions allow counting, it resumes from the held value.
- R6: Rate code 11 selects the slow tick. Codes 00, 01 and 10 select the fast tick. Ticks from the other source have no effect.
- R7: A selected tick that arrives while the armed counter holds 0 or 1 ends the countdown. In the next cycle the block drives a single-cycle pulse on the reset output (action 0) or on the power-off output (action 1). The counter then stays disarmed until the next trigger.
- R8: A trigger before expiry reloads the full count and restarts the countdown.
- R9: The reset and power-off outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_space | input | 1 | 1 selects setup space, 0 selects run-time window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no register answers |
| tick_fast | input | 1 | Single-cycle pulse of the fast (32 kHz) time base |
| tick_slow | input | 1 | Single-cycle pulse of the slow (1 Hz) time base |
| sys_rst_pulse | output | 1 | One-cycle expiry pulse requesting system reset |
| pwr_off_pulse | output | 1 | One-cycle expiry pulse requesting power-off |

## Verification
The checker assumes that each tick is a single-cycle pulse and that the two tick inputs are independent of bus activity. It also assumes that a trigger write never falls in the same cycle as a selected tick, because in that case the load takes precedence and the tick is dropped. The stimulus keeps within these assumptions: ticks and bus accesses are issued by separate tasks on separate clock cycles, each tick is held high for exactly one edge, and reads and writes never share a cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    // setup-space offsets
    localparam logic [ADDR_W-1:0] OFS_CFG = 32'h0;
    localparam logic [ADDR_W-1:0] OFS_WIN = 32'h4;
    // run-time window offsets (low three address bits)
    localparam logic [2:0] OFS_CTL = 3'd0;
    localparam logic [2:0] OFS_RLD = 3'd4;

    localparam int BASE_W = ADDR_W - 3;

    typedef enum logic [1:0] {
        RATE_FAST0 = 2'b00,
        RATE_FAST1 = 2'b01,
        RATE_FAST2 = 2'b10,
        RATE_SLOW  = 2'b11
    } rate_e;

    typedef struct packed {
        rate_e rate;
        logic  off;
    } cfg_t;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
    } win_t;

    typedef struct packed {
        logic off;
        logic pwr;
        logic run;
    } ctl_t;

    typedef enum logic [1:0] {
        EXP_NONE = 2'b00,
        EXP_RST  = 2'b01,
        EXP_PWR  = 2'b10
    } expiry_e;

    function automatic logic rate_is_slow(input rate_e r);
        return r == RATE_SLOW;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(input cfg_t c);
        return {{(DATA_W-3){1'b0}}, c.rate, c.off};
    endfunction

    function automatic logic [DATA_W-1:0] pack_win(input win_t w);
        return {w.base, 2'b00, w.en};
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctl(input ctl_t c);
        return {{(DATA_W-4){1'b0}}, c.off, c.pwr, 1'b0, c.run};
    endfunction

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
    import wdt_pkg::*;
(
    input  rate_e rate,
    input  logic  tick_fast,
    input  logic  tick_slow,
    output logic  tick
);
    always_comb begin
        if (rate_is_slow(rate))
            tick = tick_slow;
        else
            tick = tick_fast;
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_space,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output cfg_t              cfg_q,
    output ctl_t              ctl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              load
);
    win_t win_q;

    logic cfg_hit, win_hit, in_window, ctl_hit, rld_hit;

    always_comb begin
        cfg_hit   = bus_space && (bus_addr == OFS_CFG);
        win_hit   = bus_space && (bus_addr == OFS_WIN);
        in_window = !bus_space && win_q.en && (bus_addr[ADDR_W-1:3] == win_q.base);
        ctl_hit   = in_window && (bus_addr[2:0] == OFS_CTL);
        rld_hit   = in_window && (bus_addr[2:0] == OFS_RLD);
        load      = bus_wr && ctl_hit && bus_wdata[7];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '{rate: RATE_FAST0, off: 1'b1};
            win_q    <= '0;
            ctl_q    <= '0;
            reload_q <= '0;
        end else if (bus_wr) begin
            if (cfg_hit) begin
                cfg_q.off  <= bus_wdata[0];
                cfg_q.rate <= rate_e'(bus_wdata[2:1]);
            end
            if (win_hit) begin
                win_q.en   <= bus_wdata[0];
                win_q.base <= bus_wdata[DATA_W-1:3];
            end
            if (ctl_hit) begin
                ctl_q.run <= bus_wdata[0];
                ctl_q.pwr <= bus_wdata[2];
                ctl_q.off <= bus_wdata[3];
            end
            if (rld_hit)
                reload_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (cfg_hit)      bus_rdata = pack_cfg(cfg_q);
            else if (win_hit) bus_rdata = pack_win(win_q);
            else if (ctl_hit) bus_rdata = pack_ctl(ctl_q);
            else if (rld_hit) bus_rdata = {{(DATA_W-CNT_W){1'b0}}, reload_q};
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run_ok,
    input  logic             tick,
    input  logic             pwr_sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic             armed_q,
    output expiry_e          exp_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    assign step = armed_q && run_ok && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            exp_q   <= EXP_NONE;
        end else begin
            exp_q <= EXP_NONE;
            if (load) begin
                cnt_q   <= load_val;
                armed_q <= 1'b1;
            end else if (step) begin
                if (cnt_q <= ONE) begin
                    cnt_q   <= '0;
                    armed_q <= 1'b0;
                    exp_q   <= pwr_sel ? EXP_PWR : EXP_RST;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_space,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              sys_rst_pulse,
    output logic              pwr_off_pulse
);
    cfg_t             cfg_q;
    ctl_t             ctl_q;
    logic [CNT_W-1:0] reload_q;
    logic             load;
    logic             tick;
    logic             run_ok;
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    expiry_e          exp_q;

    wdt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_space (bus_space),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_q     (cfg_q),
        .ctl_q     (ctl_q),
        .reload_q  (reload_q),
        .load      (load)
    );

    wdt_tick_sel u_tsel (
        .rate      (cfg_q.rate),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .tick      (tick)
    );

    assign run_ok = !cfg_q.off && !ctl_q.off && ctl_q.run;

    wdt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (reload_q),
        .run_ok   (run_ok),
        .tick     (tick),
        .pwr_sel  (ctl_q.pwr),
        .cnt_q    (cnt_q),
        .armed_q  (armed_q),
        .exp_q    (exp_q)
    );

    assign sys_rst_pulse = (exp_q == EXP_RST);
    assign pwr_off_pulse = (exp_q == EXP_PWR);
endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sys_rst_pulse,
    input logic             pwr_off_pulse,
    input logic             load,
    input logic             run_ok,
    input logic             armed_q,
    input logic [CNT_W-1:0] cnt_q
);
    assert_no_dual_action_R9: assert property (@(posedge clk) disable iff (rst)
        !(sys_rst_pulse && pwr_off_pulse));

    assert_rst_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |=> !sys_rst_pulse);

    assert_off_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        pwr_off_pulse |=> !pwr_off_pulse);

    assert_expiry_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_pulse || pwr_off_pulse) |-> $past(run_ok && armed_q));

    assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && !run_ok) |=> $stable(cnt_q));

    assert_trigger_arms_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> armed_q);
endmodule

bind tick_watchdog tick_watchdog_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .sys_rst_pulse (sys_rst_pulse),
    .pwr_off_pulse (pwr_off_pulse),
    .load          (load),
    .run_ok        (run_ok),
    .armed_q       (armed_q),
    .cnt_q         (cnt_q)
);

// File: tb/tick_watchdog_tb_top.sv
module tick_watchdog_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_space = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        sys_rst_pulse;
    logic        pwr_off_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    typedef struct {
        int kind;   // 1 = reset pulse, 2 = power-off pulse
        int cyc;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tick_watchdog dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_space     (bus_space),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .tick_fast     (tick_fast),
        .tick_slow     (tick_slow),
        .sys_rst_pulse (sys_rst_pulse),
        .pwr_off_pulse (pwr_off_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected expiry pulses
    always @(negedge clk) begin
        if (!rst && (sys_rst_pulse || pwr_off_pulse)) begin
            int kind;
            kind = pwr_off_pulse ? 2 : 1;
            if (sys_rst_pulse && pwr_off_pulse)
                check("R9 both outputs", 32'd3, 32'd1);
            if (sb_q.size() == 0) begin
                check("R7 unexpected pulse kind", 32'(kind), 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " pulse kind"}, 32'(kind), 32'(e.kind));
                check({e.req, " pulse cycle"}, 32'(cyc), 32'(e.cyc));
            end
        end
    end

    task automatic wr(input logic sp, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_space = sp; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic sp, input logic [31:0] a,
                      input logic [31:0] exp);
        @(negedge clk);
        bus_space = sp; bus_addr = a; bus_rd = 1'b1;
        #1 check(req, bus_rdata, exp);
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    // slow: 1 picks slow input; exp: 0 none, 1 reset, 2 power-off
    task automatic tk(input string req, input bit slow, input int exp);
        @(negedge clk);
        if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
        @(posedge clk);
        #1;
        tick_slow = 1'b0; tick_fast = 1'b0;
        if (exp != 0) begin
            exp_t e;
            e.kind = exp; e.cyc = cyc; e.req = req;
            sb_q.push_back(e);
            repeat (2) @(posedge clk);
            #1 check({req, " pulse delivered"}, 32'(sb_q.size()), 32'd0);
        end else begin
            @(negedge clk);
            check({req, " outputs quiet"}, {30'b0, pwr_off_pulse, sys_rst_pulse}, 32'd0);
        end
    endtask

    localparam logic [31:0] BASE = 32'h0000_1000;

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd("R1 cfg reset", 1'b1, 32'h0, 32'h1);
        rd("R1 window reset", 1'b1, 32'h4, 32'h0);
        check("R1 outputs low", {30'b0, pwr_off_pulse, sys_rst_pulse}, 32'd0);

        // R3 window closed: writes ignored
        wr(1'b0, BASE, 32'h05);
        wr(1'b1, 32'h4, BASE | 32'h1);
        rd("R2 window field", 1'b1, 32'h4, BASE | 32'h1);
        rd("R3 ignored while closed", 1'b0, BASE, 32'h0);

        // R2 cfg fields and masking
        wr(1'b1, 32'h0, 32'hFF);
        rd("R2 cfg mask", 1'b1, 32'h0, 32'h7);
        wr(1'b1, 32'h4, BASE | 32'h7);
        rd("R2 window low bits", 1'b1, 32'h4, BASE | 32'h1);
        wr(1'b1, 32'h0, 32'h0);

        // R4 reload register width, R3 wrong base
        wr(1'b0, BASE + 4, 32'hABCD_1234);
        rd("R4 reload width", 1'b0, BASE + 4, 32'h1234);
        rd("R3 other base reads 0", 1'b0, 32'h2000, 32'h0);
        wr(1'b0, BASE + 4, 32'd3);

        // R6 fast rate, R7 reset action
        wr(1'b0, BASE, 32'h81);
        rd("R4 trigger reads 0", 1'b0, BASE, 32'h01);
        tk("R6 slow ignored", 1'b1, 0);
        tk("R6 slow ignored", 1'b1, 0);
        tk("R6 slow ignored", 1'b1, 0);
        tk("R7 t1", 1'b0, 0);
        tk("R7 t2", 1'b0, 0);
        tk("R7 reset expiry", 1'b0, 1);
        tk("R7 disarmed after expiry", 1'b0, 0);

        // R7 power-off action
        wr(1'b0, BASE + 4, 32'd2);
        wr(1'b0, BASE, 32'h85);
        rd("R4 ctl readback pwr", 1'b0, BASE, 32'h05);
        tk("R7 pwr t1", 1'b0, 0);
        tk("R7 power-off expiry", 1'b0, 2);

        // R5 control-disable holds
        wr(1'b0, BASE, 32'h89);
        rd("R4 ctl readback dis", 1'b0, BASE, 32'h09);
        tk("R5 ctl dis hold", 1'b0, 0);
        tk("R5 ctl dis hold", 1'b0, 0);
        tk("R5 ctl dis hold", 1'b0, 0);
        wr(1'b0, BASE, 32'h01);
        tk("R5 resume t1", 1'b0, 0);
        tk("R5 resume expiry", 1'b0, 1);

        // R5 config-disable holds
        wr(1'b0, BASE + 4, 32'd1);
        wr(1'b1, 32'h0, 32'h1);
        wr(1'b0, BASE, 32'h81);
        tk("R5 cfg dis hold", 1'b0, 0);
        wr(1'b1, 32'h0, 32'h0);
        tk("R5 cfg enable expiry", 1'b0, 1);

        // R5 run bit clear holds
        wr(1'b0, BASE, 32'h80);
        tk("R5 stopped hold", 1'b0, 0);
        wr(1'b0, BASE, 32'h01);
        tk("R5 run expiry", 1'b0, 1);

        // R6 slow rate code 11
        wr(1'b1, 32'h0, 32'h6);
        wr(1'b0, BASE + 4, 32'd2);
        wr(1'b0, BASE, 32'h81);
        tk("R6 fast ignored", 1'b0, 0);
        tk("R6 fast ignored", 1'b0, 0);
        tk("R6 slow t1", 1'b1, 0);
        tk("R6 slow expiry", 1'b1, 1);

        // R6 code 01 acts as fast
        wr(1'b1, 32'h0, 32'h2);
        wr(1'b0, BASE + 4, 32'd1);
        wr(1'b0, BASE, 32'h81);
        tk("R6 code01 slow ignored", 1'b1, 0);
        tk("R6 code01 fast expiry", 1'b0, 1);
        wr(1'b1, 32'h0, 32'h0);

        // R8 retrigger postpones
        wr(1'b0, BASE + 4, 32'd3);
        wr(1'b0, BASE, 32'h81);
        tk("R8 t1", 1'b0, 0);
        tk("R8 t2", 1'b0, 0);
        wr(1'b0, BASE, 32'h81);
        tk("R8 after reload t1", 1'b0, 0);
        tk("R8 after reload t2", 1'b0, 0);
        tk("R8 expiry", 1'b0, 1);

        // R7 reload of zero expires on first tick
        wr(1'b0, BASE + 4, 32'd0);
        wr(1'b0, BASE, 32'h85);
        tk("R7 zero reload expiry", 1'b0, 2);

        // R3 trigger ignored while decoding disabled
        wr(1'b0, BASE + 4, 32'd1);
        wr(1'b1, 32'h4, BASE);
        wr(1'b0, BASE, 32'h81);
        tk("R3 closed trigger ignored", 1'b0, 0);
        wr(1'b1, 32'h4, BASE | 32'h1);
        rd("R3 ctl unchanged", 1'b0, BASE, 32'h05);

        // R3 relocated window
        wr(1'b1, 32'h4, 32'h0000_2001);
        rd("R3 new base answers", 1'b0, 32'h2000, 32'h05);
        rd("R3 old base silent", 1'b0, BASE, 32'h0);
        rd("R3 reload at new base", 1'b0, 32'h2004, 32'h1);

        repeat (3) @(posedge clk);
        check("R7 scoreboard empty", 32'(sb_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule